// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block tallies per-frame events reported by an Ethernet MAC. For every received or transmitted frame the MAC raises a one-cycle strobe that carries the frame length in bytes and a set of attribute flags. The bank keeps a frame total, a byte total and a seven-bin length histogram for each direction. Receive frames also feed eight attribute counters. Transmit frames feed four. A separate counter tracks congestion drops.

Software or a management agent reads the counters through a simple read port. The requested word appears one cycle after the read request. Reading an event counter returns its value and zeroes it, so each read yields the increment since the previous read. The two byte totals are 45 bits wide and are read as two words. Reading the low word captures the upper bits in a holding register, and a later read of the high word returns that captured value. The congestion-drop counter is never cleared by a read. A statistics-clear input zeroes every counter and both holding registers at once.

Top module: `rmon_stat_bank`

## Requirements
- R1: `rd_vld` is high exactly in the cycle after a cycle with `rd_en` high. `rd_data` then holds the value the addressed counter had in the `rd_en` cycle. `rd_data` does not change in a cycle that follows a cycle without `rd_en`.
- R2: Each cycle with `rx_evt` high adds 1 to the RX frame counter (address 2) and adds `rx_len` to the 45-bit RX byte total. `tx_evt` does the same for the TX frame counter (address 20) and the TX byte total.
- R3: With `rx_evt` high, each set bit of `rx_flags` adds 1 to its counter. The bit-to-address map is: bit0 multicast at 3, bit1 broadcast at 4, bit2 FCS error at 5, bit3 pause at 6, bit4 jabber at 7, bit5 short at 8, bit6 oversize at 9, bit7 symbol error at 10.
- R4: With `tx_evt` high, each set bit of `tx_flags` adds 1 to its counter. The bit-to-address map is: bit0 multicast at 21, bit1 broadcast at 22, bit2 pause at 23, bit3 error frame (bad FCS or underrun) at 24.
- R5: Every event also adds 1 to exactly one histogram bin, chosen by its length. The bins are: up to 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 or more. RX bins sit at addresses 11–17 and TX bins at 25–31, in that order.
- R6: Reading any 32-bit counter except the congestion-drop counter clears it. If an increment lands in the same cycle as that read, the counter ends at the increment value instead of zero.
- R7: Reading a byte-total low word (RX at 0, TX at 18) returns bits 31:0. The same read captures bits 44:32 into a holding register and clears the whole 45-bit total, keeping only a same-cycle increment. Reading the high word (RX at 1, TX at 19) returns the held bits zero-extended and clears nothing.
- R8: Each `cong_drop` pulse adds 1 to the congestion-drop counter at address 32. Reading that counter does not clear it.
- R9: A cycle with `clr_stats` high leaves every counter and both holding registers at zero. This holds even when events or reads occur in the same cycle.
- R10: Addresses 33 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_stats | input | 1 | Zero all counters |
| rx_evt | input | 1 | Receive frame event strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flags | input | 8 | Receive frame attribute flags |
| tx_evt | input | 1 | Transmit frame event strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 4 | Transmit frame attribute flags |
| cong_drop | input | 1 | Congestion drop pulse |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Counter address |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Counter state can only be observed through the read port. A wrong count, a wrong histogram bin or a mis-mapped flag therefore stays hidden until the affected address is read, and then shows one cycle after the request. A clear-on-read that fails to clear shows up as a non-zero value on the second of two back-to-back reads with no events in between. A lost same-cycle increment shows as a count that is one short. A faulty holding register gives a high word that does not match the byte total, but only once that total has passed 2^32. The bench therefore drives long frames to push the totals past that point.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  localparam int CNT_W     = 32;
  localparam int BYTE_W    = 45;
  localparam int HI_W      = BYTE_W - CNT_W;
  localparam int HIST_BINS = 7;
  localparam int RX_FLAGS  = 8;
  localparam int TX_FLAGS  = 4;
  // per-direction slot layout: 0 byte low, 1 byte high, 2 frames, flags, bins
  localparam int RX_SLOTS  = 3 + RX_FLAGS + HIST_BINS;
  localparam int TX_SLOTS  = 3 + TX_FLAGS + HIST_BINS;
  localparam int TX_BASE   = RX_SLOTS;
  localparam int DROP_ADDR = RX_SLOTS + TX_SLOTS;
  localparam int ADDR_W    = $clog2(DROP_ADDR + 1);

  typedef logic [2:0] bin_t;

  function automatic bin_t len_bin(input logic [31:0] len);
    if (len <= 32'd64)        return 3'd0;
    else if (len <= 32'd127)  return 3'd1;
    else if (len <= 32'd255)  return 3'd2;
    else if (len <= 32'd511)  return 3'd3;
    else if (len <= 32'd1023) return 3'd4;
    else if (len <= 32'd1518) return 3'd5;
    else                      return 3'd6;
  endfunction
endpackage

// File: rtl/rmon_ctr.sv
module rmon_ctr #(
  parameter int W  = 32,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          clr_rd,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_amt,
  output logic [W-1:0]  cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         upd;

  // global clear beats read clear; a read clear keeps a same-cycle increment
  always_comb begin
    upd   = clr_all | clr_rd | inc_en;
    cnt_d = cnt_q;
    if (clr_all)
      cnt_d = '0;
    else if (clr_rd)
      cnt_d = inc_en ? W'(inc_amt) : '0;
    else if (inc_en)
      cnt_d = cnt_q + W'(inc_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (upd)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rmon_dir_bank.sv
module rmon_dir_bank
  import rmon_pkg::*;
#(
  parameter int NFLAG = 8,
  parameter int LEN_W = 14,
  localparam int NSLOT = 3 + NFLAG + HIST_BINS,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             evt_vld,
  input  logic [LEN_W-1:0] evt_len,
  input  logic [NFLAG-1:0] evt_flags,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_val
);
  localparam int NEV = 1 + NFLAG + HIST_BINS;

  bin_t              bin;
  logic [NEV-1:0]    ev_inc;
  logic [CNT_W-1:0]  ev_cnt [NEV];
  logic [BYTE_W-1:0] byte_cnt;
  logic              rd_lo;
  logic [HI_W-1:0]   hi_q;
  logic [HI_W-1:0]   hi_d;
  logic              hi_en;

  assign bin   = len_bin(32'(evt_len));
  assign rd_lo = rd_en && (rd_idx == '0);

  always_comb begin
    ev_inc[0] = evt_vld;
    for (int i = 0; i < NFLAG; i++)
      ev_inc[1+i] = evt_vld & evt_flags[i];
    for (int b = 0; b < HIST_BINS; b++)
      ev_inc[1+NFLAG+b] = evt_vld && (bin == 3'(b));
  end

  generate
    for (genvar g = 0; g < NEV; g++) begin : g_ev
      rmon_ctr #(.W(CNT_W), .IW(1)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .clr_rd  (rd_en && (rd_idx == IDX_W'(g + 2))),
        .inc_en  (ev_inc[g]),
        .inc_amt (1'b1),
        .cnt     (ev_cnt[g])
      );
    end
  endgenerate

  rmon_ctr #(.W(BYTE_W), .IW(LEN_W)) u_bytes (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .clr_rd  (rd_lo),
    .inc_en  (evt_vld),
    .inc_amt (evt_len),
    .cnt     (byte_cnt)
  );

  // upper byte-total bits captured at low-word read
  always_comb begin
    hi_en = clr_all | rd_lo;
    hi_d  = clr_all ? '0 : byte_cnt[BYTE_W-1:CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_q <= '0;
    else if (hi_en)
      hi_q <= hi_d;
  end

  always_comb begin
    rd_val = '0;
    if (rd_idx == IDX_W'(0))
      rd_val = byte_cnt[CNT_W-1:0];
    else if (rd_idx == IDX_W'(1))
      rd_val = CNT_W'(hi_q);
    else
      for (int g = 0; g < NEV; g++)
        if (rd_idx == IDX_W'(g + 2))
          rd_val = ev_cnt[g];
  end
endmodule

// File: rtl/rmon_stat_bank.sv
module rmon_stat_bank
  import rmon_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_stats,
  input  logic                rx_evt,
  input  logic [LEN_W-1:0]    rx_len,
  input  logic [RX_FLAGS-1:0] rx_flags,
  input  logic                tx_evt,
  input  logic [LEN_W-1:0]    tx_len,
  input  logic [TX_FLAGS-1:0] tx_flags,
  input  logic                cong_drop,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_vld,
  output logic [CNT_W-1:0]    rd_data
);
  localparam int RX_IW = $clog2(RX_SLOTS);
  localparam int TX_IW = $clog2(TX_SLOTS);

  logic             rx_hit, tx_hit, drop_hit;
  logic [RX_IW-1:0] rx_idx;
  logic [TX_IW-1:0] tx_idx;
  logic [CNT_W-1:0] rx_val, tx_val, drop_cnt, rd_sel;
  logic [CNT_W-1:0] rd_data_q, rd_data_d;
  logic             rd_vld_q;

  always_comb begin
    rx_hit   = rd_en && (rd_addr < ADDR_W'(TX_BASE));
    tx_hit   = rd_en && (rd_addr >= ADDR_W'(TX_BASE)) && (rd_addr < ADDR_W'(DROP_ADDR));
    drop_hit = rd_en && (rd_addr == ADDR_W'(DROP_ADDR));
    rx_idx   = RX_IW'(rd_addr);
    tx_idx   = TX_IW'(rd_addr - ADDR_W'(TX_BASE));
  end

  rmon_dir_bank #(.NFLAG(RX_FLAGS), .LEN_W(LEN_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (clr_stats),
    .evt_vld   (rx_evt),
    .evt_len   (rx_len),
    .evt_flags (rx_flags),
    .rd_en     (rx_hit),
    .rd_idx    (rx_idx),
    .rd_val    (rx_val)
  );

  rmon_dir_bank #(.NFLAG(TX_FLAGS), .LEN_W(LEN_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (clr_stats),
    .evt_vld   (tx_evt),
    .evt_len   (tx_len),
    .evt_flags (tx_flags),
    .rd_en     (tx_hit),
    .rd_idx    (tx_idx),
    .rd_val    (tx_val)
  );

  // congestion drops: cleared only by the global clear
  rmon_ctr #(.W(CNT_W), .IW(1)) u_drop (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_stats),
    .clr_rd  (1'b0),
    .inc_en  (cong_drop),
    .inc_amt (1'b1),
    .cnt     (drop_cnt)
  );

  always_comb begin
    if (rx_hit)        rd_sel = rx_val;
    else if (tx_hit)   rd_sel = tx_val;
    else if (drop_hit) rd_sel = drop_cnt;
    else               rd_sel = '0;
    rd_data_d = rd_en ? rd_sel : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_en;
      if (rd_en)
        rd_data_q <= rd_data_d;
    end
  end

  assign rd_vld  = rd_vld_q;
  assign rd_data = rd_data_q;
endmodule

// File: rtl/rmon_stat_bank_chk.sv
module rmon_stat_bank_chk
  import rmon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr_stats,
  input logic              rx_evt,
  input logic              tx_evt,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_vld,
  input logic [CNT_W-1:0]  rd_data
);
  logic clearable;
  assign clearable = (rd_addr < ADDR_W'(DROP_ADDR)) && (rd_addr != ADDR_W'(1)) &&
                     (rd_addr != ADDR_W'(TX_BASE + 1));

  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);
  p_data_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // back-to-back read of a clearable counter with no events in between
  p_reread_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && rd_addr == $past(rd_addr) && clearable &&
     !$past(rx_evt) && !$past(tx_evt)) |=> (rd_data == '0));

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(clr_stats) && !$past(rx_evt) && !$past(tx_evt) &&
     (rd_addr < ADDR_W'(DROP_ADDR))) |=> (rd_data == '0));

  p_hi_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == ADDR_W'(1) || rd_addr == ADDR_W'(TX_BASE + 1)))
      |=> (rd_data[CNT_W-1:HI_W] == '0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > ADDR_W'(DROP_ADDR)) |=> (rd_data == '0));
endmodule

bind rmon_stat_bank rmon_stat_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_stats (clr_stats),
  .rx_evt    (rx_evt),
  .tx_evt    (tx_evt),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_vld    (rd_vld),
  .rd_data   (rd_data)
);

// File: tb/rmon_stat_bank_test.sv
module rmon_stat_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 24;
  localparam longint unsigned M32 = 64'hFFFF_FFFF;
  localparam longint unsigned M45 = (64'd1 << 45) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_stats;
  logic          rx_evt;
  logic [LW-1:0] rx_len;
  logic [7:0]    rx_flags;
  logic          tx_evt;
  logic [LW-1:0] tx_len;
  logic [3:0]    tx_flags;
  logic          cong_drop;
  logic          rd_en;
  logic [5:0]    rd_addr;
  logic          rd_vld;
  logic [31:0]   rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint unsigned m [0:63];
  longint unsigned rxb, txb, rxhi, txhi;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmon_stat_bank #(.LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .clr_stats(clr_stats),
    .rx_evt(rx_evt), .rx_len(rx_len), .rx_flags(rx_flags),
    .tx_evt(tx_evt), .tx_len(tx_len), .tx_flags(tx_flags),
    .cong_drop(cong_drop), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  function automatic int bin_of(input int l);
    if (l <= 64) return 0;
    if (l <= 127) return 1;
    if (l <= 255) return 2;
    if (l <= 511) return 3;
    if (l <= 1023) return 4;
    if (l <= 1518) return 5;
    return 6;
  endfunction

  function automatic longint unsigned model_read(input int a);
    if (a == 0)  return rxb & M32;
    if (a == 1)  return rxhi;
    if (a == 18) return txb & M32;
    if (a == 19) return txhi;
    if (a <= 32) return m[a];
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0 || a == 1 || a == 18 || a == 19) return "R7";
    if (a == 2 || a == 20) return "R2";
    if (a >= 3 && a <= 10) return "R3";
    if ((a >= 11 && a <= 17) || (a >= 25 && a <= 31)) return "R5";
    if (a >= 21 && a <= 24) return "R4";
    if (a == 32) return "R8";
    return "R10";
  endfunction

  task automatic chk(input longint unsigned act, input longint unsigned exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m[i] = 0;
    rxb = 0; txb = 0; rxhi = 0; txhi = 0;
  endtask

  // one clock cycle; entered and left at a falling edge
  task automatic step(input bit rv, input int rl, input logic [7:0] rf,
                      input bit tv, input int tl, input logic [3:0] tf,
                      input bit cd, input bit re, input int ra,
                      input bit clr, input string tag);
    longint unsigned exp;
    logic [31:0] prev;
    string t;
    rx_evt = rv; rx_len = LW'(rl); rx_flags = rf;
    tx_evt = tv; tx_len = LW'(tl); tx_flags = tf;
    cong_drop = cd; rd_en = re; rd_addr = 6'(ra); clr_stats = clr;
    exp  = model_read(ra);
    prev = rd_data;
    if (clr) model_clear();
    else begin
      if (re) begin
        if (ra == 0)  begin rxhi = rxb >> 32; rxb = 0; end
        else if (ra == 18) begin txhi = txb >> 32; txb = 0; end
        else if (ra != 1 && ra != 19 && ra < 32) m[ra] = 0;
      end
      if (rv) begin
        m[2] = (m[2] + 1) & M32;
        for (int i = 0; i < 8; i++) if (rf[i]) m[3+i] = (m[3+i] + 1) & M32;
        m[11+bin_of(rl)] = (m[11+bin_of(rl)] + 1) & M32;
        rxb = (rxb + longint'(rl)) & M45;
      end
      if (tv) begin
        m[20] = (m[20] + 1) & M32;
        for (int i = 0; i < 4; i++) if (tf[i]) m[21+i] = (m[21+i] + 1) & M32;
        m[25+bin_of(tl)] = (m[25+bin_of(tl)] + 1) & M32;
        txb = (txb + longint'(tl)) & M45;
      end
      if (cd) m[32] = (m[32] + 1) & M32;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rd_vld, re, "R1");
    t = (tag == "") ? tag_of(ra) : tag;
    if (re) chk(rd_data, exp, t);
    else    chk(rd_data, prev, "R1");
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, 0, tag);
  endtask

  task automatic rx(input int l, input logic [7:0] f);
    step(1, l, f, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic tx(input int l, input logic [3:0] f);
    step(0, 0, 0, 1, l, f, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lens [12];
    int seed;
    void'($urandom(32'h5eed_1234));
    lens = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};
    model_clear();
    rst_n = 0; clr_stats = 0; rx_evt = 0; rx_len = 0; rx_flags = 0;
    tx_evt = 0; tx_len = 0; tx_flags = 0; cong_drop = 0; rd_en = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    chk(rd_vld, 0, "R1");
    chk(rd_data, 0, "R1");
    rst_n = 1;
    @(negedge clk);

    // reset state and unmapped addresses
    for (int a = 0; a < 40; a++) rd(a, "");

    // histogram boundaries (R5)
    foreach (lens[i]) begin rx(lens[i], 0); tx(lens[i], 0); end
    rx(40, 0); tx(9000, 0);
    for (int a = 11; a <= 17; a++) rd(a, "R5");
    for (int a = 25; a <= 31; a++) rd(a, "R5");
    rd(2, "R2"); rd(20, "R2"); rd(0, "R2"); rd(18, "R2");

    // flag mapping (R3, R4)
    rx(100, 8'b1010_0101); rx(100, 8'b0101_1010); rx(100, 8'b1000_0001);
    tx(100, 4'b0101); tx(100, 4'b1100);
    for (int a = 3; a <= 10; a++) rd(a, "R3");
    for (int a = 21; a <= 24; a++) rd(a, "R4");

    // clear-on-read with a same-cycle increment (R6)
    rx(70, 8'h01); rx(70, 8'h01);
    step(1, 70, 8'h01, 0, 0, 0, 0, 1, 3, 0, "R6");
    rd(3, "R6"); rd(3, "R6");
    step(0, 0, 0, 1, 80, 4'h8, 0, 1, 24, 0, "R6");
    rd(24, "R6");

    // byte total crosses 2^32, low read snapshots the high word (R7)
    for (int i = 0; i < 300; i++) begin
      step(1, 16000000 + i, 0, 1, 15000000, 0, 0, 0, 0, 0, "");
    end
    step(1, 5, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    rx(9, 0);
    rd(1, "R7"); rd(1, "R7"); rd(0, "R7"); rd(0, "R7");
    rd(18, "R7"); rd(19, "R7");

    // congestion drops persist across reads (R8)
    repeat (3) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "");
    rd(32, "R8"); rd(32, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32, 0, "R8");
    rd(32, "R8");

    // global clear wins over same-cycle events (R9)
    rx(200, 8'hFF); tx(3000, 4'hF);
    for (int i = 0; i < 4; i++) step(1, 2000000, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 300, 8'hFF, 1, 300, 4'hF, 1, 0, 0, 1, "R9");
    for (int a = 0; a <= 32; a++) rd(a, "R9");

    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      bit rv, tv, cd, re, clr;
      int rl, tl, ra;
      logic [7:0] rf;
      logic [3:0] tf;
      rv  = ($urandom % 3) != 0;
      tv  = ($urandom % 2) != 0;
      cd  = ($urandom % 8) == 0;
      re  = ($urandom % 2) != 0;
      clr = ($urandom % 400) == 0;
      case ($urandom % 4)
        0: rl = 40 + int'($urandom % 100);
        1: rl = 60 + int'($urandom % 1500);
        2: rl = 1500 + int'($urandom % 40);
        default: rl = 1000000 + int'($urandom % 15000000);
      endcase
      tl = 1 + int'($urandom % 9000);
      rf = 8'($urandom);
      tf = 4'($urandom);
      ra = int'($urandom % 36);
      step(rv, rl, rf, tv, tl, tf, cd, re, ra, clr, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int a = 0; a <= 34; a++) rd(a, "");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule